// File: doc/BRIEF.md
# FFT Pass Sequencer with Bank Swapping

This block is the control sequencer for a multi-pass, out-of-place FFT engine whose working storage sits in two external memory banks. A one-cycle start pulse captures the direction, the transform length (as a base-2 logarithm) and a drain-mode bit. After a fixed launch delay, the sequencer issues one sample address per cycle for each pass. The pass count is the length exponent divided by five, rounded up. Two bank selects tell the memory system where to read and where to write. The read-side select flips when issuing of a new pass begins. The write-side select flips only once the last sample of the previous pass has come out of the engine's pipeline. That pipeline is modelled here as a fixed-latency delay line of tagged valid bits.

Writes of intermediate passes are flagged with `wr_valid` and writes of the final pass with `res_valid`. After the final result has been written, `done` pulses for one cycle. The sequencer then relaunches on its own with the captured settings, unless a stop pulse arrived during the transform. With drain mode set, the next pass is not read until the previous pass has fully left the pipeline, which suits single-port banks. With drain mode clear, consecutive passes are issued back to back, which needs dual-port banks.

The controller has six states:
- IDLE: waits for start.
- LAUNCH: counts down the launch delay.
- ISSUE: emits addresses.
- DRAIN: waits for the pipeline to empty between passes in drain mode.
- FLUSH: waits for the last result of the final pass.
- FINISH: the done cycle.

Its transitions are:
- Any state moves to LAUNCH on start.
- LAUNCH moves to ISSUE when the countdown ends.
- ISSUE moves to DRAIN at the end of a non-final pass in drain mode.
- ISSUE stays in ISSUE at the end of a non-final pass in overlap mode.
- ISSUE moves to FLUSH at the end of the final pass.
- DRAIN moves to ISSUE when the last sample of the pass leaves the pipeline.
- FLUSH moves to FINISH when the last result leaves the pipeline.
- FINISH moves to LAUNCH for an automatic restart, or to IDLE when a stop is pending.

Top module: `fft_pass_sequencer`

## Requirements
- R1: During and right after reset: `issue_valid`, `wr_valid`, `res_valid` and `done` are 0, `in_bank` is 0 and `out_bank` is 1.
- R2: `dir_in`, `len_log2` and `drain_mode` are captured only in the cycle where `start` is 1; later changes have no effect. A start while a transform runs discards it, so none of its samples is written afterwards.
- R3: If `start` is 1 in cycle s, `issue_valid` is first 1 in cycle s+7. Within a pass, `issue_addr` runs 0,1,...,2^L-1, one per cycle, where L = captured `len_log2` (legal range 8..20).
- R4: A transform has ceil(L/5) passes.
- R5: `in_bank` is 0 while pass 1 is issued and inverts in the cycle where the first address of each later pass is issued.
- R6: `out_bank` is 1 for pass 1 writes and inverts in the cycle after the last write of each non-final pass. During final results it equals the pass count mod 2 (1 = bank B for odd, 0 = bank A for even).
- R7: With drain mode 1, the first issue of a pass comes PIPE_LAT+1 cycles after the last issue of the previous pass. With drain mode 0, it comes in the very next cycle.
- R8: Each issued sample is written exactly PIPE_LAT cycles later: as `wr_valid` for non-final passes and as `res_valid` for the final pass; the two never overlap.
- R9: `done` is 1 for exactly one cycle, the cycle after the last `res_valid`.
- R10: Without a pending stop, a new transform starts automatically: the first issue comes 7 cycles after the `done` cycle, with the same captured settings.
- R11: A `stop` pulse while active makes the sequencer go idle after the next `done`. A stop while idle is ignored. A start together with a stop runs exactly one transform.
- R12: `dir_out` holds the direction captured by the last start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle start / abort-and-restart pulse |
| stop | input | 1 | One-cycle pulse: current transform is the last |
| dir_in | input | 1 | Direction, 1 = forward, 0 = inverse |
| len_log2 | input | 5 | Transform length exponent, 8..20 |
| drain_mode | input | 1 | 1 = drain pipeline between passes, 0 = overlap passes |
| issue_valid | output | 1 | Address for data and twiddle read is valid |
| issue_addr | output | 20 | Sample index within the current pass |
| in_bank | output | 1 | Bank to read pass input from |
| out_bank | output | 1 | Bank to write pass output to |
| wr_valid | output | 1 | Intermediate-pass write strobe |
| res_valid | output | 1 | Final-result write strobe |
| done | output | 1 | One-cycle completion pulse |
| dir_out | output | 1 | Captured direction for the datapath |

## Verification
The hardest situation to reach is one where overlapping passes make the two bank selects disagree. In that situation the read side already points at the new pass while the old pass is still draining into the other bank. A three-pass transform in overlap mode is needed to see two such windows within one transform. The bench runs such a transform and lets it restart automatically, then stops it mid-run. A second transform is aborted by a fresh start while its pipeline is full, so that the flush can be observed at the write strobes. A behavioural reference model, built from a timestamped queue of issued samples, is compared with every output on every clock.

// File: rtl/fft_seq_pkg.sv
package fft_seq_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_LAUNCH,
        S_ISSUE,
        S_DRAIN,
        S_FLUSH,
        S_FINISH
    } seq_state_t;

    // Tag carried through the pipeline model with each issued sample
    typedef struct packed {
        logic vld;
        logic last;   // last sample of its pass
        logic fin;    // belongs to the final pass
    } pipe_tag_t;

    // Passes needed for a length of 2^lg with five radix-2 stages per pass
    function automatic int pass_total(input int lg);
        return (lg + 4) / 5;
    endfunction

endpackage

// File: rtl/fft_pipe_model.sv
module fft_pipe_model
    import fft_seq_pkg::*;
#(
    parameter int DEPTH = 12
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      flush,
    input  pipe_tag_t tag_in,
    output pipe_tag_t tag_out
);

    pipe_tag_t stage [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        if (g == 0) begin : g_head
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)     stage[g] <= '0;
                else if (flush) stage[g] <= '0;
                else            stage[g] <= tag_in;
            end
        end else begin : g_body
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)     stage[g] <= '0;
                else if (flush) stage[g] <= '0;
                else            stage[g] <= stage[g-1];
            end
        end
    end

    assign tag_out = stage[DEPTH-1];

    // R2
    flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !tag_out.vld);

endmodule

// File: rtl/fft_bank_tracker.sv
module fft_bank_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic in_flip,
    input  logic out_flip,
    output logic in_bank,
    output logic out_bank
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_bank  <= 1'b0;
            out_bank <= 1'b1;
        end else if (arm) begin
            in_bank  <= 1'b0;
            out_bank <= 1'b1;
        end else begin
            if (in_flip)  in_bank  <= ~in_bank;
            if (out_flip) out_bank <= ~out_bank;
        end
    end

endmodule

// File: rtl/fft_pass_sequencer.sv
module fft_pass_sequencer
    import fft_seq_pkg::*;
#(
    parameter int MAX_LOG2   = 20,
    parameter int MIN_LOG2   = 8,
    parameter int PIPE_LAT   = 12,
    parameter int LAUNCH_DLY = 7
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           start,
    input  logic                           stop,
    input  logic                           dir_in,
    input  logic [$clog2(MAX_LOG2+1)-1:0]  len_log2,
    input  logic                           drain_mode,
    output logic                           issue_valid,
    output logic [MAX_LOG2-1:0]            issue_addr,
    output logic                           in_bank,
    output logic                           out_bank,
    output logic                           wr_valid,
    output logic                           res_valid,
    output logic                           done,
    output logic                           dir_out
);

    localparam int LEN_W  = $clog2(MAX_LOG2 + 1);
    localparam int PASS_W = $clog2(MAX_LOG2 / 5 + 2);
    localparam int LCNT_W = $clog2(LAUNCH_DLY);

    seq_state_t           st, st_nx;
    logic [LEN_W-1:0]     len_q;
    logic                 drain_q, dir_q, stop_pend;
    logic [LCNT_W-1:0]    lcnt;
    logic [PASS_W-1:0]    pass_idx;
    logic [MAX_LOG2-1:0]  addr, last_addr;
    logic                 at_last, final_pass, new_pass, arm, halt;
    pipe_tag_t            head, tail;
    logic                 tail_last;

    assign last_addr  = MAX_LOG2'((64'd1 << len_q) - 64'd1);
    assign at_last    = (addr == last_addr);
    assign final_pass = (int'(pass_idx) == pass_total(int'(len_q)) - 1);
    assign tail_last  = tail.vld & tail.last;
    assign halt       = stop_pend | stop;

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_nx;
    end

    // ---------------- next state ----------------
    always_comb begin
        st_nx = st;
        if (start) begin
            st_nx = S_LAUNCH;
        end else begin
            unique case (st)
                S_IDLE:   st_nx = S_IDLE;
                S_LAUNCH: if (lcnt == '0) st_nx = S_ISSUE;
                S_ISSUE:  if (at_last) begin
                              if (final_pass)   st_nx = S_FLUSH;
                              else if (drain_q) st_nx = S_DRAIN;
                          end
                S_DRAIN:  if (tail_last) st_nx = S_ISSUE;
                S_FLUSH:  if (tail_last && tail.fin) st_nx = S_FINISH;
                S_FINISH: st_nx = halt ? S_IDLE : S_LAUNCH;
                default:  st_nx = S_IDLE;
            endcase
        end
    end

    assign arm      = start | ((st == S_FINISH) & ~halt);
    assign new_pass = ((st == S_ISSUE) & at_last & ~final_pass & ~drain_q)
                    | ((st == S_DRAIN) & tail_last);

    // ---------------- capture, counters ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q     <= LEN_W'(MIN_LOG2);
            drain_q   <= 1'b0;
            dir_q     <= 1'b0;
            stop_pend <= 1'b0;
            lcnt      <= '0;
            addr      <= '0;
            pass_idx  <= '0;
        end else begin
            if (start) begin
                len_q     <= len_log2;
                drain_q   <= drain_mode;
                dir_q     <= dir_in;
                stop_pend <= stop;
            end else if (st == S_FINISH && halt) begin
                stop_pend <= 1'b0;
            end else if (st != S_IDLE && stop) begin
                stop_pend <= 1'b1;
            end

            if (arm)                             lcnt <= LCNT_W'(LAUNCH_DLY - 2);
            else if (st == S_LAUNCH && lcnt != '0) lcnt <= lcnt - LCNT_W'(1);

            if (arm) begin
                addr     <= '0;
                pass_idx <= '0;
            end else if (new_pass) begin
                addr     <= '0;
                pass_idx <= pass_idx + PASS_W'(1);
            end else if (st == S_ISSUE && !at_last) begin
                addr     <= addr + MAX_LOG2'(1);
            end
        end
    end

    // ---------------- pipeline model and banks ----------------
    assign head.vld  = (st == S_ISSUE);
    assign head.last = at_last;
    assign head.fin  = final_pass;

    fft_pipe_model #(.DEPTH(PIPE_LAT)) u_pipe (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (start),
        .tag_in  (head),
        .tag_out (tail)
    );

    fft_bank_tracker u_banks (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm      (arm),
        .in_flip  (new_pass),
        .out_flip (tail_last & ~tail.fin & ~start),
        .in_bank  (in_bank),
        .out_bank (out_bank)
    );

    // ---------------- outputs ----------------
    always_comb begin
        issue_valid = (st == S_ISSUE);
        issue_addr  = addr;
        wr_valid    = tail.vld & ~tail.fin;
        res_valid   = tail.vld & tail.fin;
        done        = (st == S_FINISH);
        dir_out     = dir_q;
    end

    // ---------------- assertions ----------------
    // R3
    issue_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && issue_addr != last_addr && !start)
        |=> (issue_valid && issue_addr == $past(issue_addr) + MAX_LOG2'(1)));

    // R3
    launch_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_LAUNCH && lcnt == '0 && !start) |=> issue_valid);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    done_follows_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(res_valid));

    // R6
    out_bank_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(out_bank) |-> ($past(wr_valid) || $past(start) || $past(done)));

    // R5
    in_bank_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(in_bank) |-> ((issue_valid && issue_addr == '0) || $past(start) || $past(done)));

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_IDLE && !start) |=> !issue_valid);

endmodule

// File: tb/fft_pass_sequencer_test.sv
module fft_pass_sequencer_test;

    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 12;
    localparam int AW         = 20;

    localparam int M_IDLE = 0, M_LAUNCH = 1, M_ISSUE = 2, M_DRAIN = 3, M_FLUSH = 4, M_FINISH = 5;

    logic clk, rst_n, start, stop, dir_in, drain_mode;
    logic [4:0] len_log2;
    logic issue_valid, in_bank, out_bank, wr_valid, res_valid, done, dir_out;
    logic [AW-1:0] issue_addr;

    int checks = 0;
    int fails  = 0;

    fft_pass_sequencer #(.MAX_LOG2(AW), .MIN_LOG2(8), .PIPE_LAT(LAT), .LAUNCH_DLY(7)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .dir_in(dir_in),
        .len_log2(len_log2), .drain_mode(drain_mode), .issue_valid(issue_valid),
        .issue_addr(issue_addr), .in_bank(in_bank), .out_bank(out_bank),
        .wr_valid(wr_valid), .res_valid(res_valid), .done(done), .dir_out(dir_out)
    );

    initial begin
        clk = 1'b0;
        forever #(CLK_PERIOD/2) clk = ~clk;
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // ---------------- reference model ----------------
    typedef struct { int t; bit last; bit fin; } rec_t;
    rec_t q[$];
    int  cyc = 0;
    int  m_st, m_lcnt, m_addr, m_pass, m_len;
    bit  m_in, m_out, m_dir, m_drain, m_pend;

    // independent trackers
    int  cap_len = 8;
    bit  cap_drain = 0;
    int  arm_at = 0;
    bit  arm_by_done = 0;
    bit  want_first = 0;
    int  res_cnt = 0, bursts = 0, last_iss = 0;
    bit  prev_iv = 0;

    task automatic model_reset();
        q.delete();
        m_st = M_IDLE; m_lcnt = 0; m_addr = 0; m_pass = 0; m_len = 8;
        m_in = 0; m_out = 1; m_dir = 0; m_drain = 0; m_pend = 0;
    endtask

    task automatic model_rearm();
        m_st = M_LAUNCH; m_lcnt = 5; m_addr = 0; m_pass = 0; m_in = 0; m_out = 1;
    endtask

    task automatic model_edge();
        int n, np;
        bit tv, tl, tf;
        n  = 1 << m_len;
        np = (m_len + 4) / 5;
        tv = 0; tl = 0; tf = 0;
        if (m_st == M_ISSUE) q.push_back('{cyc + LAT, m_addr == n - 1, m_pass == np - 1});
        if (q.size() > 0 && q[0].t == cyc) begin
            tv = 1; tl = q[0].last; tf = q[0].fin;
            void'(q.pop_front());
        end
        if (start) begin
            q.delete();
            m_len = int'(len_log2); m_dir = dir_in; m_drain = drain_mode; m_pend = stop;
            model_rearm();
        end else begin
            if (m_st != M_IDLE && stop) m_pend = 1;
            if (tv && tl && !tf) m_out = ~m_out;
            case (m_st)
                M_LAUNCH: if (m_lcnt == 0) m_st = M_ISSUE; else m_lcnt--;
                M_ISSUE: begin
                    if (m_addr == n - 1) begin
                        if (m_pass == np - 1) m_st = M_FLUSH;
                        else if (m_drain) m_st = M_DRAIN;
                        else begin m_pass++; m_addr = 0; m_in = ~m_in; end
                    end else m_addr++;
                end
                M_DRAIN: if (tv && tl) begin m_pass++; m_addr = 0; m_in = ~m_in; m_st = M_ISSUE; end
                M_FLUSH: if (tv && tl && tf) m_st = M_FINISH;
                M_FINISH: begin
                    if (m_pend || stop) begin m_st = M_IDLE; m_pend = 0; end
                    else model_rearm();
                end
                default: ;
            endcase
        end
        cyc++;
    endtask

    always @(negedge clk) begin
        if (!rst_n) begin
            model_reset();
            cyc++;
        end else begin
            bit ev, ew, er;
            int np;
            model_edge();
            ev = (q.size() > 0 && q[0].t == cyc);
            ew = ev && !q[0].fin;
            er = ev && q[0].fin;
            chk("R3", "issue_valid", int'(issue_valid), int'(m_st == M_ISSUE));
            if (m_st == M_ISSUE) chk("R3", "issue_addr", int'(issue_addr), m_addr);
            chk("R5", "in_bank", int'(in_bank), int'(m_in));
            chk("R6", "out_bank", int'(out_bank), int'(m_out));
            chk("R8", "wr_valid", int'(wr_valid), int'(ew));
            chk("R8", "res_valid", int'(res_valid), int'(er));
            chk("R9", "done", int'(done), int'(m_st == M_FINISH));
            chk("R12", "dir_out", int'(dir_out), int'(m_dir));

            // independent pass-level checks
            np = (cap_len + 4) / 5;
            if (start) begin
                arm_at = cyc - 1; arm_by_done = 0; want_first = 1;
                res_cnt = 0; bursts = 0;
            end
            if (issue_valid && !prev_iv) begin
                if (want_first) begin
                    if (arm_by_done) chk("R10", "restart launch gap", cyc - arm_at, 7);
                    else             chk("R3", "start launch gap", cyc - arm_at, 7);
                    want_first = 0;
                end else begin
                    chk("R7", "drain gap", cyc - last_iss, LAT + 1);
                end
                bursts++;
            end
            if (issue_valid) last_iss = cyc;
            if (res_valid) begin
                res_cnt++;
                chk("R6", "final bank", int'(out_bank), np % 2);
            end
            if (done) begin
                chk("R8", "result count", res_cnt, 1 << cap_len);
                chk("R4", "pass bursts", bursts, cap_drain ? np : 1);
                arm_at = cyc; arm_by_done = 1; want_first = 1;
                res_cnt = 0; bursts = 0;
            end
            prev_iv = issue_valid;
        end
    end

    // ---------------- stimulus ----------------
    task automatic cycles(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic fire(input bit d, input int l, input bit dr, input bit stp);
        @(negedge clk); #1;
        start = 1; stop = stp; dir_in = d; len_log2 = 5'(l); drain_mode = dr;
        cap_len = l; cap_drain = dr;
        @(negedge clk); #1;
        start = 0; stop = 0;
        // scramble: must have no effect until the next start (R2)
        dir_in = ~d; len_log2 = 5'(l == 8 ? 9 : 8); drain_mode = ~dr;
    endtask

    task automatic pulse_stop();
        @(negedge clk); #1; stop = 1;
        @(negedge clk); #1; stop = 0;
    endtask

    task automatic wait_done();
        do @(negedge clk); while (done !== 1'b1);
    endtask

    initial begin
        int seen;
        rst_n = 0; start = 0; stop = 0; dir_in = 0; len_log2 = 5'd8; drain_mode = 0;
        cycles(3);
        chk("R1", "reset issue_valid", int'(issue_valid), 0);
        chk("R1", "reset writes", int'(wr_valid | res_valid), 0);
        chk("R1", "reset done", int'(done), 0);
        chk("R1", "reset in_bank", int'(in_bank), 0);
        chk("R1", "reset out_bank", int'(out_bank), 1);
        #1 rst_n = 1;
        cycles(5);

        // stop while idle is ignored
        pulse_stop();
        seen = 0;
        for (int i = 0; i < 20; i++) begin @(negedge clk); seen += int'(issue_valid); end
        chk("R11", "idle stop ignored", seen, 0);

        // T1: two passes, drain mode, start+stop together => single run
        fire(1'b1, 8, 1'b1, 1'b1);
        cycles(30);
        chk("R2", "direction captured", int'(dir_out), 1);
        wait_done();
        seen = 0;
        for (int i = 0; i < 40; i++) begin @(negedge clk); seen += int'(issue_valid); end
        chk("R11", "no restart after stop", seen, 0);

        // T2: three passes, overlap mode, automatic restart, then stop
        fire(1'b0, 11, 1'b0, 1'b0);
        wait_done();
        cycles(100);
        chk("R10", "restarted transform issuing", int'(issue_valid), 1);
        pulse_stop();
        wait_done();
        seen = 0;
        for (int i = 0; i < 40; i++) begin @(negedge clk); seen += int'(issue_valid); end
        chk("R11", "idle after stopped restart", seen, 0);

        // T3: drain mode run aborted by a fresh start
        fire(1'b1, 10, 1'b1, 1'b0);
        cycles(300);
        fire(1'b0, 8, 1'b0, 1'b0);
        seen = 0;
        for (int i = 0; i < 12; i++) begin @(negedge clk); seen += int'(wr_valid | res_valid); end
        chk("R2", "aborted samples flushed", seen, 0);
        pulse_stop();
        wait_done();
        cycles(20);

        // T4: three passes in drain mode, single run
        fire(1'b1, 13, 1'b1, 1'b1);
        wait_done();
        cycles(20);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL R9 watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule